// File: doc/BRIEF.md
# Octal DAC Serial Command Receiver

This block is the digital front end of an eight-channel digital-to-analog converter. A host writes it through three wires: a serial clock, a data line and a load strobe. Each command word carries a channel address, a range bit and an output code. The block shifts the word in, and the load strobe steers it into a per-channel input latch. The block then drives eight codes and eight range bits to the converter cores.

A fourth control input, the defer line, picks when the converters see new values. With defer low, the falling edge of the load strobe also writes the addressed channel's output latch, so that output changes at once. With defer high, writes stay in the input latches. A later falling edge of defer copies every input latch into its output latch in the same clock cycle, so several channels can be staged and then applied together.

All four serial-side inputs are asynchronous to the system clock. Each one passes through a synchronizer chain and an edge detector before any logic acts on it.

Top module: `octal_dac_cmd_rx`

## Requirements
- R1: While the synchronous active-low reset is asserted, and immediately after it is released, every output code is 0 and every range bit is 0. Both the input latches and the output latches are cleared.
- R2: A falling edge of `ser_clk` while `ser_load` is high shifts `ser_data` into the 12-bit command register, most significant bit first. A falling edge of `ser_clk` while `ser_load` is low leaves the register unchanged.
- R3: In the command word, bits [11:9] are the channel address: code 0 selects channel 0, and each higher code selects the next channel, up to code 7 for channel 7.
- R4: Command bit [8] is the range bit and bits [7:0] are the code. Both are stored per channel and appear on that channel's slice of `dac_range` and `dac_code`.
- R5: A falling edge of `ser_load` while `defer_upd` is low writes the addressed channel's input and output latches. No other channel's outputs change.
- R6: A falling edge of `ser_load` while `defer_upd` is high writes only the input latch, and every output stays unchanged.
- R7: A falling edge of `defer_upd` copies all eight input latches into their output latches in the same cycle.
- R8: A falling edge of `ser_load` after fewer than 12 shifted bits latches whatever the command register holds at that moment. Bits from earlier words are not cleared, and the number of shifted bits is not checked.
- R9: An output change caused by an edge on `ser_load` or `defer_upd` appears on the third rising edge of `clk` after the edge reaches the pin, counting the first edge that samples the new level as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; acts on its falling edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; high while shifting, falling edge latches the word |
| defer_upd | input | 1 | High holds new values in the input latches; falling edge applies all of them |
| dac_code | output | 64 | Eight 8-bit output codes, channel n at bits [8n+7:8n] |
| dac_range | output | 8 | Range bit per channel: 0 selects x1, 1 selects x2 |

## Verification
Each edge on a serial-side pin takes two clocks to cross the synchronizer. The edge detector then acts on the third rising edge of `clk`, so a latched word or a bulk update is visible on the outputs after that third edge. The bench holds every serial phase for four system clocks and compares all outputs only after four more falling edges of `clk`, which leaves margin past that edge. A dedicated latency test samples one channel after the second rising edge, where the old value is required, and after the third, where the new value is required. This pins R9 to the exact cycle.

// File: rtl/octal_dac_pkg.sv
package octal_dac_pkg;
   // bit positions of the serial-side inputs inside the synchronized bundle
   localparam int unsigned PIN_SCLK  = 0;
   localparam int unsigned PIN_SDATA = 1;
   localparam int unsigned PIN_LOAD  = 2;
   localparam int unsigned PIN_DEFER = 3;
   localparam int unsigned PIN_COUNT = 4;
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] fall
);
   logic [WIDTH-1:0] stg [STAGES];
   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
         prev <= '0;
      end else begin
         stg[0] <= async_in;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
         prev <= stg[STAGES-1];
      end
   end

   assign lvl  = stg[STAGES-1];
   assign fall = prev & ~stg[STAGES-1];
endmodule

// File: rtl/dac_cmd_shift.sv
module dac_cmd_shift #(
   parameter int unsigned WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word
);
   always_ff @(posedge clk) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
   end
endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic              direct,
   input  logic              bulk,
   input  logic [CODE_W-1:0] new_code,
   input  logic              new_rng,
   output logic [CODE_W-1:0] in_code,
   output logic              in_rng,
   output logic [CODE_W-1:0] out_code,
   output logic              out_rng
);
   logic hit;
   assign hit = sel & wr_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_code  <= '0;
         in_rng   <= 1'b0;
         out_code <= '0;
         out_rng  <= 1'b0;
      end else begin
         if (hit) begin
            in_code <= new_code;
            in_rng  <= new_rng;
         end
         if (bulk) begin
            out_code <= hit ? new_code : in_code;
            out_rng  <= hit ? new_rng  : in_rng;
         end else if (hit && direct) begin
            out_code <= new_code;
            out_rng  <= new_rng;
         end
      end
   end
endmodule

// File: rtl/octal_dac_cmd_rx.sv
module octal_dac_cmd_rx #(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned CODE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_clk,
   input  logic                     ser_data,
   input  logic                     ser_load,
   input  logic                     defer_upd,
   output logic [NUM_CH*CODE_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        dac_range
);
   import octal_dac_pkg::*;

   localparam int unsigned ADDR_W  = $clog2(NUM_CH);
   localparam int unsigned WORD_W  = ADDR_W + 1 + CODE_W;
   localparam int unsigned RNG_POS = CODE_W;

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be a power of two and at least 2");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("CODE_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [PIN_COUNT-1:0] pins, s_lvl, s_fall;
   always_comb begin
      pins            = '0;
      pins[PIN_SCLK]  = ser_clk;
      pins[PIN_SDATA] = ser_data;
      pins[PIN_LOAD]  = ser_load;
      pins[PIN_DEFER] = defer_upd;
   end

   dac_in_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pins), .lvl(s_lvl), .fall(s_fall)
   );

   logic              shift_en;
   logic [WORD_W-1:0] cmd_word;
   assign shift_en = s_fall[PIN_SCLK] & s_lvl[PIN_LOAD];

   dac_cmd_shift #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
      .bit_in(s_lvl[PIN_SDATA]), .word(cmd_word)
   );

   logic [ADDR_W-1:0] cmd_addr;
   logic              cmd_rng;
   logic [CODE_W-1:0] cmd_code;
   logic              load_fall, defer_lvl, defer_fall, direct;
   assign cmd_addr   = cmd_word[WORD_W-1 -: ADDR_W];
   assign cmd_rng    = cmd_word[RNG_POS];
   assign cmd_code   = cmd_word[CODE_W-1:0];
   assign load_fall  = s_fall[PIN_LOAD];
   assign defer_lvl  = s_lvl[PIN_DEFER];
   assign defer_fall = s_fall[PIN_DEFER];
   assign direct     = ~defer_lvl;

   logic [NUM_CH*CODE_W-1:0] in_code_flat;
   logic [NUM_CH-1:0]        in_rng_flat;

   for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
      dac_chan_slot #(.CODE_W(CODE_W)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .sel(cmd_addr == ADDR_W'(c)),
         .wr_en(load_fall), .direct(direct), .bulk(defer_fall),
         .new_code(cmd_code), .new_rng(cmd_rng),
         .in_code(in_code_flat[c*CODE_W +: CODE_W]), .in_rng(in_rng_flat[c]),
         .out_code(dac_code[c*CODE_W +: CODE_W]), .out_rng(dac_range[c])
      );
   end
endmodule

// File: rtl/octal_dac_cmd_rx_chk.sv
module octal_dac_cmd_rx_chk #(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned CODE_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned WORD_W = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     shift_en,
   input logic                     data_lvl,
   input logic                     load_fall,
   input logic                     defer_lvl,
   input logic                     defer_fall,
   input logic [WORD_W-1:0]        cmd_word,
   input logic [NUM_CH*CODE_W-1:0] in_code_flat,
   input logic [NUM_CH-1:0]        in_rng_flat,
   input logic [NUM_CH*CODE_W-1:0] dac_code,
   input logic [NUM_CH-1:0]        dac_range
);
   logic              pend;
   logic [ADDR_W-1:0] addr_q;
   logic [CODE_W-1:0] code_q;
   logic              rng_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0; addr_q <= '0; code_q <= '0; rng_q <= 1'b0;
      end else begin
         pend   <= load_fall & ~defer_lvl & ~defer_fall;
         addr_q <= cmd_word[WORD_W-1 -: ADDR_W];
         code_q <= cmd_word[CODE_W-1:0];
         rng_q  <= cmd_word[CODE_W];
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (dac_code == '0 && dac_range == '0));

   p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> cmd_word == {$past(cmd_word[WORD_W-2:0]), $past(data_lvl)});

   p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(cmd_word));

   p_direct_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> (dac_code[addr_q*CODE_W +: CODE_W] == code_q && dac_range[addr_q] == rng_q));

   p_outputs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!defer_fall && !(load_fall && !defer_lvl)) |=> ($stable(dac_code) && $stable(dac_range)));

   p_bulk_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (defer_fall && !load_fall) |=> (dac_code == $past(in_code_flat) && dac_range == $past(in_rng_flat)));
endmodule

bind octal_dac_cmd_rx octal_dac_cmd_rx_chk #(
   .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
   .data_lvl(s_lvl[octal_dac_pkg::PIN_SDATA]),
   .load_fall(load_fall), .defer_lvl(defer_lvl), .defer_fall(defer_fall),
   .cmd_word(cmd_word), .in_code_flat(in_code_flat), .in_rng_flat(in_rng_flat),
   .dac_code(dac_code), .dac_range(dac_range)
);

// File: tb/octal_dac_cmd_rx_test.sv
module octal_dac_cmd_rx_test;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b1, ser_data = 1'b0, ser_load = 1'b1, defer_upd = 1'b0;
   logic [63:0] dac_code;
   logic [7:0]  dac_range;

   octal_dac_cmd_rx uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .defer_upd(defer_upd),
      .dac_code(dac_code), .dac_range(dac_range)
   );

   int checks = 0, errors = 0;
   bit done = 0;
   logic [7:0]  m_in_code [8];
   logic        m_in_rng  [8];
   logic [7:0]  m_out_code[8];
   logic        m_out_rng [8];
   logic [11:0] m_sh = '0;

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_bit(input logic b);
      ser_data = b; cyc(4);
      ser_clk = 1'b0; cyc(4);
      ser_clk = 1'b1;
      if (ser_load) m_sh = {m_sh[10:0], b};
   endtask

   task automatic send_bits(input logic [11:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
   endtask

   task automatic model_load();
      int a;
      a = int'(m_sh[11:9]);
      m_in_code[a] = m_sh[7:0];
      m_in_rng[a]  = m_sh[8];
      if (!defer_upd) begin
         m_out_code[a] = m_sh[7:0];
         m_out_rng[a]  = m_sh[8];
      end
   endtask

   task automatic pulse_load();
      ser_load = 1'b0; cyc(4);
      model_load();
      ser_load = 1'b1; cyc(4);
   endtask

   task automatic pulse_defer();
      defer_upd = 1'b0; cyc(4);
      for (int c = 0; c < 8; c++) begin
         m_out_code[c] = m_in_code[c];
         m_out_rng[c]  = m_in_rng[c];
      end
      defer_upd = 1'b1; cyc(4);
   endtask

   task automatic check_ch(input string tag, input int c);
      checks++;
      if (dac_code[c*8 +: 8] !== m_out_code[c] || dac_range[c] !== m_out_rng[c]) begin
         errors++;
         $display("FAIL %s ch%0d actual code=%h range=%b expected code=%h range=%b",
                  tag, c, dac_code[c*8 +: 8], dac_range[c], m_out_code[c], m_out_rng[c]);
      end
   endtask

   task automatic check_all(input string tag);
      cyc(4);
      for (int c = 0; c < 8; c++) check_ch(tag, c);
   endtask

   // R1: cleared outputs at and after reset
   task automatic t_reset();
      for (int c = 0; c < 8; c++) begin
         m_in_code[c] = '0; m_in_rng[c] = 1'b0; m_out_code[c] = '0; m_out_rng[c] = 1'b0;
      end
      rst_n = 1'b0; cyc(3);
      for (int c = 0; c < 8; c++) check_ch("R1 during reset", c);
      rst_n = 1'b1;
      check_all("R1 after reset");
   endtask

   // R3 R4 R5: immediate write to every channel with distinct codes and ranges
   task automatic t_immediate();
      defer_upd = 1'b0;
      for (int c = 0; c < 8; c++) begin
         send_bits({3'(c), 1'(c % 2), 8'(8'h1F * (c + 1) ^ 8'hA5)}, 12);
         pulse_load();
         check_all("R5 immediate write");
      end
      send_bits({3'd7, 1'b0, 8'hFF}, 12); pulse_load();
      check_all("R3 top address");
      send_bits({3'd0, 1'b1, 8'h00}, 12); pulse_load();
      check_all("R4 range with zero code");
   endtask

   // R6 R7: staged writes held, then applied together
   task automatic t_deferred();
      defer_upd = 1'b1; cyc(6);
      send_bits({3'd1, 1'b1, 8'h3C}, 12); pulse_load();
      send_bits({3'd4, 1'b0, 8'hC3}, 12); pulse_load();
      send_bits({3'd6, 1'b1, 8'h81}, 12); pulse_load();
      check_all("R6 outputs held while deferred");
      pulse_defer();
      check_all("R7 bulk apply");
      defer_upd = 1'b0; cyc(6);
      check_all("R7 defer release stable");
   endtask

   // R2: serial clock edges with the load strobe low are ignored
   task automatic t_clk_no_load();
      send_bits({3'd2, 1'b1, 8'h5A}, 12); pulse_load();
      check_all("R2 baseline write");
      ser_load = 1'b0; cyc(4);
      send_bits(12'hFFF, 5);
      ser_load = 1'b1; cyc(4);
      pulse_load();
      check_all("R2 ignored shifts with load low");
   endtask

   // R8: short word latches the partially shifted register
   task automatic t_short();
      send_bits({3'd3, 1'b0, 8'h96}, 12);
      send_bits(12'h00B, 4);
      pulse_load();
      check_all("R8 short word");
   endtask

   // R9: the output changes on the third rising edge after the load edge
   task automatic t_latency();
      defer_upd = 1'b0; cyc(6);
      send_bits({3'd5, 1'b1, 8'h77}, 12);
      ser_load = 1'b0;
      cyc(2);
      check_ch("R9 old value after two edges", 5);
      cyc(1);
      model_load();
      check_ch("R9 new value after third edge", 5);
      ser_load = 1'b1; cyc(4);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      cyc(1);
      t_reset();
      t_immediate();
      t_deferred();
      t_clk_no_load();
      t_short();
      t_latency();
      finish_run();
   end
endmodule